// File: doc/BRIEF.md
# Cascadable Dual Timer with Prescaler

The block holds two 8-bit up-counters, called timer 0 and timer 1. Each counter advances on a one-cycle tick taken from one of three dividers of the system clock. The first divider has a fixed ratio. The second uses a 16-bit programmable divisor, and the third uses a 32-bit programmable divisor. A counter's select field can also choose no tick at all, which freezes that counter. When a counter rolls over from all ones to zero, it can latch an interrupt flag. The flag stays set until software writes the control register again.

In cascade mode the two counters act as one 16-bit counter. Timer 1 is the low byte and follows its own tick source. Timer 0 is the high byte and advances only when timer 1 rolls over. The counts are always visible at the ports in three forms:

- each counter on its own;
- a combined 16-bit view;
- a status word that also carries the fixed divider ratio.

Software writes control and divisor values through a simple one-cycle write port. Decoding of the system address lies outside the block.

Top module: `dtm_top`

## Requirements
- R1: After an asynchronous active-low reset, every register is zero. Both counts read 0, both interrupts are low and the status word reads {FIXED_DIV, 8'h00, 8'h00}.
- R2: Each divider pulses its tick for one cycle every N cycles. A divisor of 0 acts as 1, so the tick is high every cycle. The fixed divider uses N = FIXED_DIV. Writing a programmable divisor restarts that divider's phase, so the first tick comes N cycles after the write.
- R3: The control field sel0 at bits [1:0] and the field sel1 at bits [3:2] pick each counter's tick source. The codes are 0 for the fixed divider, 1 for the 16-bit divider, 2 for the 32-bit divider and 3 for no tick, in which case the counter holds.
- R4: With cascade off (control bit 6 = 0), each counter adds 1 on every tick of its own source and rolls over from 8'hFF to 8'h00.
- R5: With cascade on (control bit 6 = 1), timer 1 adds 1 on the source chosen by sel1. Timer 0 adds 1 only in the cycle where timer 1 rolls over from 8'hFF to 8'h00, and sel0 has no effect.
- R6: The output count16 equals {timer0, timer1}. The status word equals {FIXED_DIV[15:0], timer0, timer1}.
- R7: A counter's interrupt output goes high the cycle after that counter rolls over, if its enable bit is set. The enable for timer 0 is control bit 4 and the enable for timer 1 is control bit 5. The interrupt stays high until the next control write. A control write clears both interrupts, and this clear wins over a rollover in the same cycle.
- R8: Writes go to address 0 for control (bits [6:0]), address 1 for the 16-bit divisor (bits [15:0]) and address 2 for the 32-bit divisor. Writes to any other address change nothing. Every register write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register write address |
| wr_data | input | 32 | Register write data |
| count0 | output | CNT_W (8) | Timer 0 count |
| count1 | output | CNT_W (8) | Timer 1 count |
| count16 | output | 2*CNT_W (16) | Combined count {timer0, timer1} |
| status_word | output | 16+2*CNT_W (32) | {fixed ratio, timer0, timer1} |
| irq0 | output | 1 | Sticky rollover interrupt of timer 0 |
| irq1 | output | 1 | Sticky rollover interrupt of timer 1 |

## Verification
A divider phase that is off shows at the ports as a count step that comes early or late. This appears within one divider period of the fault, because every count port is compared against the reference model in every cycle. A bad cascade carry or a stuck select makes timer 0 step at the wrong time, which is visible in the very next cycle. A flag that is set wrongly, or not cleared, appears on irq0 or irq1 one cycle after the rollover or the control write that should have decided it. A full cascade rollover is run, so a fault in the high-byte carry into the interrupt path also reaches the ports.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  typedef enum logic [1:0] {
    SRC_FIXED = 2'd0,
    SRC_DIV16 = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  typedef struct packed {
    logic cascade;
    logic ien1;
    logic ien0;
    src_e sel1;
    src_e sel0;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // divisor of zero behaves as one
  function automatic logic [31:0] eff_div(input logic [31:0] d);
    return (d == 32'd0) ? 32'd1 : d;
  endfunction

  function automatic logic pick_tick(input src_e s, input logic t_fix,
                                     input logic t_16, input logic t_32);
    case (s)
      SRC_FIXED: return t_fix;
      SRC_DIV16: return t_16;
      SRC_DIV32: return t_32;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dtm_divider.sv
module dtm_divider
  import dtm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [WIDTH-1:0] divisor,
  output logic             tick
);

  logic [WIDTH-1:0] phase;
  logic [31:0]      limit;

  assign limit = eff_div(32'(divisor)) - 32'd1;
  assign tick  = (32'(phase) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= '0;
    else              phase <= phase + WIDTH'(1);
  end

endmodule

// File: rtl/dtm_counter.sv
module dtm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ien,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         wrap,
  output logic         flag
);

  logic [W:0] nxt;

  assign nxt  = {1'b0, count} + (W+1)'(1);
  assign wrap = inc & nxt[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= nxt[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag <= 1'b0;
    else if (clr)         flag <= 1'b0;
    else if (wrap && ien) flag <= 1'b1;
  end

endmodule

// File: rtl/dtm_regs.sv
module dtm_regs
  import dtm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output ctrl_t             ctrl,
  output logic [15:0]       div16,
  output logic [31:0]       div32,
  output logic              ctrl_wr,
  output logic              div16_wr,
  output logic              div32_wr
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_D16  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_D32  = ADDR_W'(2);

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign div16_wr = wr_en && (wr_addr == A_D16);
  assign div32_wr = wr_en && (wr_addr == A_D32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      div16 <= '0;
      div32 <= '0;
    end else begin
      if (ctrl_wr)  ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (div16_wr) div16 <= wr_data[15:0];
      if (div32_wr) div32 <= wr_data;
    end
  end

endmodule

// File: rtl/dtm_top.sv
module dtm_top
  import dtm_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter int          ADDR_W    = 3,
  parameter logic [15:0] FIXED_DIV = 16'd5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [CNT_W-1:0]      count0,
  output logic [CNT_W-1:0]      count1,
  output logic [2*CNT_W-1:0]    count16,
  output logic [16+2*CNT_W-1:0] status_word,
  output logic                  irq0,
  output logic                  irq1
);

  ctrl_t       ctrl;
  logic [15:0] div16;
  logic [31:0] div32;
  logic        ctrl_wr, div16_wr, div32_wr;

  // named internal events, used by the checker
  logic       tick_fix, tick_16, tick_32;
  logic       tick0, tick1;
  logic       inc0, inc1;
  logic       wrap0, wrap1;
  logic       casc, ien0, ien1;
  logic [1:0] sel0, sel1;

  dtm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .div16(div16), .div32(div32),
    .ctrl_wr(ctrl_wr), .div16_wr(div16_wr), .div32_wr(div32_wr)
  );

  generate
    if (FIXED_DIV <= 16'd1) begin : g_fix_bypass
      assign tick_fix = 1'b1;
    end else begin : g_fix_div
      dtm_divider #(.WIDTH(16)) u_fix (
        .clk(clk), .rst_n(rst_n), .restart(1'b0),
        .divisor(FIXED_DIV), .tick(tick_fix)
      );
    end
  endgenerate

  dtm_divider #(.WIDTH(16)) u_div16 (
    .clk(clk), .rst_n(rst_n), .restart(div16_wr),
    .divisor(div16), .tick(tick_16)
  );

  dtm_divider #(.WIDTH(32)) u_div32 (
    .clk(clk), .rst_n(rst_n), .restart(div32_wr),
    .divisor(div32), .tick(tick_32)
  );

  assign casc = ctrl.cascade;
  assign ien0 = ctrl.ien0;
  assign ien1 = ctrl.ien1;
  assign sel0 = ctrl.sel0;
  assign sel1 = ctrl.sel1;

  assign tick0 = pick_tick(ctrl.sel0, tick_fix, tick_16, tick_32);
  assign tick1 = pick_tick(ctrl.sel1, tick_fix, tick_16, tick_32);

  assign inc1 = tick1;
  assign inc0 = casc ? wrap1 : tick0;

  dtm_counter #(.W(CNT_W)) u_cnt1 (
    .clk(clk), .rst_n(rst_n), .inc(inc1), .ien(ien1), .clr(ctrl_wr),
    .count(count1), .wrap(wrap1), .flag(irq1)
  );

  dtm_counter #(.W(CNT_W)) u_cnt0 (
    .clk(clk), .rst_n(rst_n), .inc(inc0), .ien(ien0), .clr(ctrl_wr),
    .count(count0), .wrap(wrap0), .flag(irq0)
  );

  assign count16     = {count0, count1};
  assign status_word = {FIXED_DIV, count0, count1};

endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count0,
  input logic [CNT_W-1:0] count1,
  input logic             irq0,
  input logic             irq1,
  input logic             ctrl_wr,
  input logic             casc,
  input logic [1:0]       sel0,
  input logic             ien1,
  input logic             wrap1
);

  assert_step0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count0 != $past(count0)) |-> (count0 == CNT_W'($past(count0) + 1'b1)));

  assert_step1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count1 != $past(count1)) |-> (count1 == CNT_W'($past(count1) + 1'b1)));

  assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(casc) && (count0 != $past(count0)))
      |-> (($past(count1) == '1) && (count1 == '0)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(casc) && ($past(sel0) == 2'd3)) |-> (count0 == $past(count0)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq0) && !$past(ctrl_wr)) |-> irq0);

  assert_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq1) |-> ($past(wrap1) && $past(ien1)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_wr) |-> (!irq0 && !irq1));

endmodule

bind dtm_top dtm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count0(count0), .count1(count1),
  .irq0(irq0), .irq1(irq1), .ctrl_wr(ctrl_wr), .casc(casc),
  .sel0(sel0), .ien1(ien1), .wrap1(wrap1)
);

// File: tb/dtm_top_test.sv
`timescale 1ns/1ps
module dtm_top_test;

  localparam int FIXN = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  count0, count1;
  logic [15:0] count16;
  logic [31:0] status_word;
  logic        irq0, irq1;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  dtm_top #(.CNT_W(8), .ADDR_W(3), .FIXED_DIV(16'(FIXN))) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count0(count0), .count1(count1),
    .count16(count16), .status_word(status_word), .irq0(irq0), .irq1(irq1)
  );

  // behavioural reference model
  longint m_ph_f, m_ph16, m_ph32, m_d16, m_d32;
  int     m_ctrl, m_t0, m_t1;
  bit     m_f0, m_f1;

  function automatic bit tick_of(longint ph, longint d);
    longint n;
    n = (d == 0) ? 1 : d;
    return ph == n - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph_f = 0; m_ph16 = 0; m_ph32 = 0; m_d16 = 0; m_d32 = 0;
      m_ctrl = 0; m_t0 = 0; m_t1 = 0; m_f0 = 0; m_f1 = 0;
    end else begin
      bit tf, t16, t32, ta, tb, w0, w1, cw;
      int s0, s1;
      tf  = tick_of(m_ph_f, FIXN);
      t16 = tick_of(m_ph16, m_d16);
      t32 = tick_of(m_ph32, m_d32);
      s0 = m_ctrl & 3;
      s1 = (m_ctrl >> 2) & 3;
      ta = (s0 == 0) ? tf : (s0 == 1) ? t16 : (s0 == 2) ? t32 : 1'b0;
      tb = (s1 == 0) ? tf : (s1 == 1) ? t16 : (s1 == 2) ? t32 : 1'b0;
      w0 = 0; w1 = 0;
      if (tb) begin
        w1 = (m_t1 == 255);
        m_t1 = (m_t1 + 1) % 256;
      end
      if (((m_ctrl >> 6) & 1) != 0 ? w1 : ta) begin
        w0 = (m_t0 == 255);
        m_t0 = (m_t0 + 1) % 256;
      end
      cw = wr_en && (wr_addr == 3'd0);
      if (cw) begin
        m_f0 = 0; m_f1 = 0;
      end else begin
        if (w0 && ((m_ctrl >> 4) & 1) != 0) m_f0 = 1;
        if (w1 && ((m_ctrl >> 5) & 1) != 0) m_f1 = 1;
      end
      m_ph_f = tf ? 0 : m_ph_f + 1;
      if (wr_en && wr_addr == 3'd1) begin m_ph16 = 0; m_d16 = wr_data[15:0]; end
      else m_ph16 = t16 ? 0 : m_ph16 + 1;
      if (wr_en && wr_addr == 3'd2) begin m_ph32 = 0; m_d32 = wr_data; end
      else m_ph32 = t32 ? 0 : m_ph32 + 1;
      if (cw) m_ctrl = int'(wr_data[6:0]);
    end
  end

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    check("count0", count0, m_t0);
    check("count1", count1, m_t1);
    check("count16 (R6)", count16, (m_t0 << 8) | m_t1);
    check("status_word (R6)", status_word, (longint'(FIXN) << 16) | (m_t0 << 8) | m_t1);
    check("irq0 (R7)", irq0, m_f0);
    check("irq1 (R7)", irq1, m_f1);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    run(3);
    @(negedge clk) rst_n = 1'b1;
    run(2);

    tag = "R2";                       // fixed divider, then 16-bit divider
    run(40);
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h01);
    run(30);
    wr(3'd1, 32'd0);
    run(20);
    wr(3'd1, 32'd7);
    run(45);

    tag = "R3";                       // sel0=div32, sel1=off
    wr(3'd2, 32'd2);
    wr(3'd0, 32'h0E);
    run(30);

    tag = "R4";                       // both every cycle, ien0 only
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h19);
    run(300);

    tag = "R7";                       // clear, then enable both
    wr(3'd0, 32'h19);
    run(10);
    wr(3'd0, 32'h39);
    run(300);
    wr(3'd0, 32'h39);
    run(5);

    tag = "R5 R6";                    // cascade, sel0 off, ien0
    wr(3'd0, 32'h5B);
    run(66000);

    tag = "R8";                       // unmapped addresses
    for (int a = 3; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    run(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule